// File: doc/BRIEF.md
# EEPROM Page Write Latch Controller

This block sits between a two-wire serial slave front end and a 2048-byte memory array, seen as 128 pages of 16 bytes. The front end hands over each received data byte as a single-cycle write request with an 11-bit byte address. The block does not write these bytes to the array at once. It gathers them into a 16-entry page latch and writes only the entries that were filled. The write to the array starts on the STOP pulse that ends the transfer.

After the STOP, the block walks the latch and drives one array write per filled entry, in ascending offset order. It then holds `busy` for a write-cycle time set by a parameter and counted in clocks. While `busy` is high, new byte requests get a negative response, so the front end can withhold its acknowledge. A write-protect input guards the upper half of the address space (bit 10 set). When it is high, bytes aimed at that half are acknowledged but dropped. When it is low, every address is writable. An unconnected protect pin is expected to be tied low outside the block.

Top module: `pagewr_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_we` and `resp_vld` are all low.
- R2: The page (address bits 10:4) is taken from the first accepted byte of a transfer. Each accepted byte goes to latch offset `wr_addr[3:0]` within that page, and the upper address bits of later bytes are ignored.
- R3: The offset wraps from 15 back to 0, so a later byte written to an offset that is already filled replaces the earlier one.
- R4: On commit, one array write is issued per filled offset, in strictly ascending offset order, at address {page, offset}. Offsets that were never filled are not written.
- R5: `mem_we` is never high while `busy` is low, so nothing reaches the array before the STOP.
- R6: A STOP while idle with no filled latch entries (no bytes, or only protected bytes) issues no write and leaves `busy` low.
- R7: A STOP with at least one filled entry raises `busy` in the next cycle. `busy` then stays high for exactly 16 + `TWC_CYCLES` cycles: 16 commit steps plus the timed write cycle.
- R8: A byte request while `busy` is high gets `resp_ack`=0 and is discarded. A STOP while `busy` is high has no effect.
- R9: When `wp`=1, bytes whose page lies in the upper half (page bit 6, address bit 10, equal to 1) are acknowledged but not latched. When `wp`=0, all pages are writable.
- R10: `resp_vld` pulses one cycle after each `wr_req`, and `resp_ack`=1 only if the request was accepted. A request in the same cycle as `stop_pulse` is refused.
- R11: After a commit the latch is empty, and the next transfer chooses a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Single-cycle byte write request from the front end |
| wr_addr | input | ADDR_W (11) | Byte address of the request |
| wr_data | input | DATA_W (8) | Data byte of the request |
| stop_pulse | input | 1 | Single-cycle pulse marking a valid STOP |
| wp | input | 1 | Write protect for the upper address half |
| resp_vld | output | 1 | Response to a request is valid |
| resp_ack | output | 1 | 1: request accepted, 0: refused |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W (11) | Array write address |
| mem_wdata | output | DATA_W (8) | Array write data |
| busy | output | 1 | Commit or internal write cycle in progress |

## Verification
The bench builds the block with `TWC_CYCLES`=12 and the default 11-bit, 16-byte page geometry. With this short write cycle, hundreds of complete transfers fit in the run, and the busy window can be counted cycle by cycle against 16+12. Random transfers use random pages, start offsets, lengths from 1 to 22 bytes (beyond the wrap) and protect settings. A bench model of the array is compared with the writes seen on the memory port. Directed cases cover:
- empty and fully protected STOPs;
- requests and STOPs during busy;
- a request that coincides with STOP;
- a page change in the middle of a transfer.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_WAIT   = 2'd2
  } pwl_state_e;
endpackage

// File: rtl/pwl_latch.sv
module pwl_latch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  valid
);
  logic [DATA_W-1:0] store [DEPTH];

  // Data storage: one write port, registered read, no reset (RAM friendly).
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
    rd_data <= store[rd_off];
  end

  // Fill flags per offset.
  always_ff @(posedge clk) begin
    if (rst || clr) valid <= '0;
    else if (wr_en) valid[wr_off] <= 1'b1;
  end
endmodule

// File: rtl/pwl_guard.sv
module pwl_guard #(
  parameter int PAGE_W = 7
) (
  input  logic              wp,
  input  logic              txn_open,
  input  logic [PAGE_W-1:0] page_q,
  input  logic [PAGE_W-1:0] req_page,
  output logic              blocked
);
  logic eff_hi;
  // The protected half is selected by the top page bit; the page in force is
  // the captured one once a transfer is open, else the incoming one.
  always_comb begin
    eff_hi  = txn_open ? page_q[PAGE_W-1] : req_page[PAGE_W-1];
    blocked = wp & eff_hi;
  end
endmodule

// File: rtl/pwl_seq.sv
module pwl_seq
  import pwl_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TWC_CYCLES = 12,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int CNT_W = (TWC_CYCLES > 1) ? $clog2(TWC_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_pulse,
  input  logic             any_valid,
  output logic             rd_en,
  output logic [OFF_W-1:0] rd_off,
  output logic             clr,
  output logic             busy
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TWC_CYCLES - 1);

  pwl_state_e state, state_nx;
  logic [OFF_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (stop_pulse && any_valid) state_nx = ST_COMMIT;
      ST_COMMIT: if (idx == LAST_OFF) state_nx = ST_WAIT;
      ST_WAIT:   if (cnt == LAST_CNT) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      state <= state_nx;
      busy  <= (state_nx != ST_IDLE);
      idx   <= (state == ST_COMMIT) ? idx + 1'b1 : '0;
      cnt   <= (state == ST_WAIT)   ? cnt + 1'b1 : '0;
    end
  end

  assign rd_en  = (state == ST_COMMIT);
  assign rd_off = idx;
  assign clr    = (state == ST_COMMIT) && (idx == LAST_OFF);
endmodule

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TWC_CYCLES = 12,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_pulse,
  input  logic              wp,
  output logic              resp_vld,
  output logic              resp_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  logic                  busy_int;
  logic                  accept, blocked, latch_we;
  logic                  txn_open;
  logic [PAGE_W-1:0]     page_q;
  logic                  rd_en, clr;
  logic [OFF_W-1:0]      rd_off;
  logic [DATA_W-1:0]     rd_data;
  logic [PAGE_BYTES-1:0] valid;
  logic                  p1_en;
  logic [OFF_W-1:0]      p1_off;

  assign accept   = wr_req & ~busy_int & ~stop_pulse;
  assign latch_we = accept & ~blocked;

  pwl_guard #(.PAGE_W(PAGE_W)) u_guard (
    .wp       (wp),
    .txn_open (txn_open),
    .page_q   (page_q),
    .req_page (wr_addr[ADDR_W-1:OFF_W]),
    .blocked  (blocked)
  );

  pwl_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (latch_we),
    .wr_off  (wr_addr[OFF_W-1:0]),
    .wr_data (wr_data),
    .clr     (clr),
    .rd_off  (rd_off),
    .rd_data (rd_data),
    .valid   (valid)
  );

  pwl_seq #(.DEPTH(PAGE_BYTES), .TWC_CYCLES(TWC_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .stop_pulse (stop_pulse),
    .any_valid  (|valid),
    .rd_en      (rd_en),
    .rd_off     (rd_off),
    .clr        (clr),
    .busy       (busy_int)
  );

  // Transfer tracking: page captured from the first accepted byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      txn_open <= 1'b0;
      page_q   <= '0;
    end else if (stop_pulse && !busy_int) begin
      txn_open <= 1'b0;
    end else if (accept && !txn_open) begin
      txn_open <= 1'b1;
      page_q   <= wr_addr[ADDR_W-1:OFF_W];
    end
  end

  // Commit pipeline: read issue -> flag stage -> registered array port.
  always_ff @(posedge clk) begin
    if (rst) begin
      p1_en     <= 1'b0;
      p1_off    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      resp_vld  <= 1'b0;
      resp_ack  <= 1'b0;
    end else begin
      p1_en     <= rd_en & valid[rd_off];
      p1_off    <= rd_off;
      mem_we    <= p1_en;
      mem_addr  <= {page_q, p1_off};
      mem_wdata <= rd_data;
      resp_vld  <= wr_req;
      resp_ack  <= accept;
    end
  end

  assign busy = busy_int;
endmodule

// File: rtl/pagewr_ctrl_chk.sv
module pagewr_ctrl_chk #(
  parameter int ADDR_W     = 11,
  parameter int OFF_W      = 4,
  parameter int PAGE_BYTES = 16,
  parameter int TWC_CYCLES = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic              stop_pulse,
  input logic              resp_vld,
  input logic              resp_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy
);
  localparam int TOTAL = PAGE_BYTES + TWC_CYCLES;
  logic [31:0] blen;

  always_ff @(posedge clk) begin
    if (rst) blen <= '0;
    else if (busy) blen <= blen + 1;
    else blen <= '0;
  end

  initial AST_TWC_MIN: assert (TWC_CYCLES >= 2); // R7

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !mem_we && !resp_vld)); // R1
  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_we); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(stop_pulse)); // R7
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst) (!busy && blen != 0) |-> (blen == TOTAL)); // R7
  AST_BUSY_NAK: assert property (@(posedge clk) disable iff (rst) ($past(busy) && $past(wr_req)) |-> !resp_ack); // R8
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst) $past(wr_req) |-> resp_vld); // R10
  AST_RESP_ONLY: assert property (@(posedge clk) disable iff (rst) !$past(wr_req) |-> (!resp_vld && !resp_ack)); // R10
  AST_STOP_NAK: assert property (@(posedge clk) disable iff (rst) ($past(wr_req) && $past(stop_pulse)) |-> !resp_ack); // R10
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:OFF_W])); // R4
  AST_OFF_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0]))); // R4
endmodule

bind pagewr_ctrl pagewr_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_BYTES(PAGE_BYTES), .TWC_CYCLES(TWC_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .stop_pulse(stop_pulse),
  .resp_vld(resp_vld), .resp_ack(resp_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy)
);

// File: tb/pagewr_ctrl_bench.sv
module pagewr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int PAGE_BYTES = 16;
  localparam int TWC = 12;
  localparam int MEM_SIZE = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_req = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic stop_pulse = 1'b0;
  logic wp = 1'b0;
  logic resp_vld, resp_ack, mem_we, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] got_mem [MEM_SIZE];
  logic [7:0] exp_mem [MEM_SIZE];
  logic [7:0] lat_d [PAGE_BYTES];
  bit         lat_v [PAGE_BYTES];
  int  wr_cnt = 0;
  int  order_err = 0;
  bit  have_last = 0;
  int  last_off = 0;
  bit  collecting = 0;
  int  early_we = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagewr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .TWC_CYCLES(TWC))
    u_pagewr_ctrl (
      .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .stop_pulse(stop_pulse), .wp(wp), .resp_vld(resp_vld), .resp_ack(resp_ack),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy));

  always @(negedge clk) begin
    if (mem_we) begin
      got_mem[mem_addr] = mem_wdata;
      wr_cnt++;
      if (collecting) early_we++;
      if (have_last && int'(mem_addr[3:0]) <= last_off) order_err++;
      have_last = 1;
      last_off = int'(mem_addr[3:0]);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat_count();
    int n = 0;
    for (int i = 0; i < PAGE_BYTES; i++) if (lat_v[i]) n++;
    return n;
  endfunction

  function automatic int mem_mismatch();
    int n = 0;
    for (int i = 0; i < MEM_SIZE; i++) if (got_mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic send_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit exp_ack, input string req);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    check(resp_vld && (resp_ack == exp_ack), req, int'(resp_ack), int'(exp_ack));
  endtask

  // Byte into the bench latch model when accepted.
  task automatic model_byte(input logic [6:0] page, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    if (!(wp && page[6])) begin
      lat_d[a[3:0]] = d;
      lat_v[a[3:0]] = 1;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < PAGE_BYTES; i++) lat_v[i] = 0;
  endtask

  // Issue STOP and check commit outcome against model.
  task automatic stop_and_check(input logic [6:0] page, input string tag);
    int n;
    int expn;
    expn = lat_count();
    wr_cnt = 0; have_last = 0; order_err = 0;
    collecting = 0;
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
    if (expn == 0) begin
      n = 0;
      for (int i = 0; i < 24; i++) begin
        if (busy) n++;
        @(negedge clk);
      end
      check(n == 0 && wr_cnt == 0, {"R6 ", tag}, n + wr_cnt, 0);
    end else begin
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check(n == PAGE_BYTES + TWC, {"R7 ", tag}, n, PAGE_BYTES + TWC);
      for (int i = 0; i < PAGE_BYTES; i++)
        if (lat_v[i]) exp_mem[{page, 4'(i)}] = lat_d[i];
      check(wr_cnt == expn, {"R4 count ", tag}, wr_cnt, expn);
      check(order_err == 0, {"R4 order ", tag}, order_err, 0);
    end
    check(mem_mismatch() == 0, {"R2 R3 R9 content ", tag}, mem_mismatch(), 0);
    check(early_we == 0, {"R5 ", tag}, early_we, 0);
    clear_model();
  endtask

  task automatic run_txn(input logic [6:0] page, input int start, input int len, input bit wpv, input bit scramble);
    logic [ADDR_W-1:0] a;
    logic [7:0] d;
    wp = wpv;
    collecting = 1;
    for (int i = 0; i < len; i++) begin
      a[3:0] = 4'(start + i);
      a[10:4] = (scramble && i > 0) ? 7'($urandom) : page;
      d = 8'($urandom);
      model_byte(page, a, d);
      send_byte(a, d, 1'b1, "R10 accept");
    end
    stop_and_check(page, "txn");
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_SIZE; i++) begin got_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    clear_model();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_we && !resp_vld, "R1 reset", int'(busy) + int'(mem_we) + int'(resp_vld), 0);

    // R6: address-only transfer
    stop_and_check(7'd3, "empty");
    // R9 R6: all bytes protected -> no cycle
    run_txn(7'h50, 0, 5, 1'b1, 1'b0);
    // R9: wp low, upper half writable
    run_txn(7'h50, 2, 4, 1'b0, 1'b0);
    // R9: wp high, lower half still writable
    run_txn(7'h05, 7, 3, 1'b1, 1'b0);
    // R3: wrap beyond 16 bytes
    run_txn(7'h11, 10, 22, 1'b0, 1'b0);
    // R2: later upper address bits ignored
    run_txn(7'h22, 14, 6, 1'b0, 1'b1);

    // R8: request and STOP during busy ignored; R11 new page next
    begin
      logic [7:0] d0;
      collecting = 1;
      d0 = 8'hA5;
      model_byte(7'h30, {7'h30, 4'd1}, d0);
      send_byte({7'h30, 4'd1}, d0, 1'b1, "R10 accept");
      wr_cnt = 0; have_last = 0; collecting = 0;
      stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
      exp_mem[{7'h30, 4'd1}] = d0;
      clear_model();
      send_byte({7'h30, 4'd2}, 8'h3C, 1'b0, "R8 nak while busy");
      stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(!busy && wr_cnt == 1, "R8 stop during busy ignored", wr_cnt, 1);
      check(mem_mismatch() == 0, "R8 byte discarded", mem_mismatch(), 0);
      // R11: empty latch after commit
      stop_and_check(7'h30, "R11 empty after commit");
      run_txn(7'h31, 0, 2, 1'b0, 1'b0);
    end

    // R10: request together with STOP is refused
    collecting = 1;
    wr_req = 1'b1; wr_addr = {7'h40, 4'd0}; wr_data = 8'h77; stop_pulse = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; stop_pulse = 1'b0;
    check(resp_vld && !resp_ack, "R10 stop collision nak", int'(resp_ack), 0);
    stop_and_check(7'h40, "R10 collision empty");

    // Random transfers
    for (int t = 0; t < 150; t++) begin
      run_txn(7'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(1, 22)),
              bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule